// File: doc/BRIEF.md
# Instruction Look-Ahead Queue

This block feeds a processor's execution stage from a two-deep instruction look-ahead. It keeps a 16-bit instruction counter that addresses program memory. Returned words go into a fetch-side slot and an execute-side slot, and a separate immediate register holds operand data. Memory reads use a simple request/ready handshake, and each returned word is taken in the cycle in which ready is high. The execution side sees the instruction it is running in the execute slot and the following word in the fetch slot. A 32-bit instruction spans both slots.

When a new word arrives and the fetch slot is already full, three things happen in the same clock. The fetch slot moves into the execute slot, and the new word is written to both the fetch slot and the immediate register. If the instruction now executing carries an immediate operand, the decoder raises a flag. The queue then refetches only the fetch slot, so the immediate register keeps the operand and no third queue slot is needed. A jump load or a reset empties both slots and refills them from the new counter value. The counter can be read at any time so that a return link can be saved.

Top module: `prefetch_queue`

## Requirements
- R1: Each accepted fetch (memReq and memRdy both high in a cycle without jumpLoad) advances icOut by one, wrapping modulo 2^16. While memReq is high, memAddr equals icOut.
- R2: A cycle with jumpLoad high loads icOut from jumpAddr and clears execValid and fetchValid. memReq is low during that cycle, so a word offered in it is discarded. Two fetches from the new address then refill the queue.
- R3: After reset, icOut is 0, both valid flags are 0, and memReq is high with memAddr 0.
- R4: A word accepted while fetchValid is 0 is stored in the fetch slot only, and execValid is left unchanged.
- R5: A word accepted while fetchValid is 1 and execValid is 0 does three things in one clock. The old fetch word moves to execWord, the new word goes to both fetchWord and immWord, and both valid flags become 1.
- R6: While both slots are valid, raising hasImm for the executing instruction clears fetchValid and refetches the fetch slot. Neither execWord nor immWord changes. A second assertion of hasImm for the same instruction causes no further refetch.
- R7: advReady is high when both slots are valid and no immediate refetch is still owed. An advance in such a cycle clears execValid, and the next accepted word then shifts the queue as in R5.
- R8: memInstr, memSpace and memRead (instruction read, memory space, read direction) are all high exactly when memReq is high, and all low otherwise.
- R9: While memReq is high and memRdy is low, icOut and every slot hold their values. An advance while advReady is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | output | 1 | Fetch request |
| memAddr | output | 16 | Fetch address |
| memInstr | output | 1 | Transfer is an instruction read |
| memSpace | output | 1 | Transfer targets memory space |
| memRead | output | 1 | Transfer direction is read |
| memRdy | input | 1 | Memory has the word; fetch completes |
| memData | input | 16 | Returned word |
| advance | input | 1 | Executing instruction retires |
| hasImm | input | 1 | Executing instruction uses an immediate operand |
| advReady | output | 1 | An advance would be accepted |
| jumpLoad | input | 1 | Load the counter and flush the queue |
| jumpAddr | input | 16 | New counter value |
| icOut | output | 16 | Instruction counter readout |
| execWord | output | 16 | Execute-side word |
| execValid | output | 1 | Execute slot holds a word |
| fetchWord | output | 16 | Fetch-side word |
| fetchValid | output | 1 | Fetch slot holds a word |
| immWord | output | 16 | Immediate register |

## Verification
The memory model returns a word that is a distinct function of its address. The first test fills the queue from reset with ready held low for several cycles, which separates a fetch that waits for ready from one that completes too early. Plain advances are then compared with advances of an instruction carrying an immediate. This shows whether the immediate register survives the extra refetch and whether execution resumes at the word after the operand. A jump to the top address, made while a fetch is pending and ready is offered, checks three things: the discarded word, counter wrap-around, and the two-fetch refill order.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef struct packed {
    logic loadIc;
    logic stepIc;
    logic loadFetch;
    logic moveToExec;
  } pfqStrobes_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memRdy,
  input  logic        advance,
  input  logic        hasImm,
  input  logic        jumpLoad,
  output logic        memReq,
  output logic        advReady,
  output logic        execValid,
  output logic        fetchValid,
  output pfqStrobes_t strobes
);
  logic immOwed;
  logic immHeld;
  logic accept;
  logic retire;

  assign memReq   = (~fetchValid | ~execValid) & ~jumpLoad;
  assign accept   = memReq & memRdy;
  // an immediate refetch is owed once per executing instruction
  assign immOwed  = execValid & fetchValid & hasImm & ~immHeld;
  assign advReady = execValid & fetchValid & ~(hasImm & ~immHeld);
  assign retire   = advance & advReady;

  always_comb begin
    strobes            = '0;
    strobes.loadIc     = jumpLoad;
    strobes.stepIc     = accept;
    strobes.loadFetch  = accept;
    strobes.moveToExec = accept & fetchValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execValid  <= 1'b0;
      fetchValid <= 1'b0;
      immHeld    <= 1'b0;
    end else if (jumpLoad) begin
      execValid  <= 1'b0;
      fetchValid <= 1'b0;
      immHeld    <= 1'b0;
    end else begin
      if (accept) begin
        fetchValid <= 1'b1;
        if (fetchValid) execValid <= 1'b1;
      end
      if (immOwed) begin
        fetchValid <= 1'b0;
        immHeld    <= 1'b1;
      end
      if (retire) begin
        execValid <= 1'b0;
        immHeld   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobes_t       strobes,
  input  logic [WORD_W-1:0] jumpAddr,
  input  logic [WORD_W-1:0] memData,
  output logic [WORD_W-1:0] icOut,
  output logic [WORD_W-1:0] execWord,
  output logic [WORD_W-1:0] fetchWord,
  output logic [WORD_W-1:0] immWord
);
  localparam logic [WORD_W-1:0] IcInit = WORD_W'(RESET_ADDR);
  localparam logic [WORD_W-1:0] IcOne  = WORD_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      icOut     <= IcInit;
      execWord  <= '0;
      fetchWord <= '0;
      immWord   <= '0;
    end else begin
      if (strobes.loadIc)      icOut <= jumpAddr;
      else if (strobes.stepIc) icOut <= icOut + IcOne;
      if (strobes.loadFetch)   fetchWord <= memData;
      if (strobes.moveToExec) begin
        execWord <= fetchWord;
        immWord  <= memData;
      end
    end
  end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic [WORD_W-1:0] memAddr,
  output logic              memInstr,
  output logic              memSpace,
  output logic              memRead,
  input  logic              memRdy,
  input  logic [WORD_W-1:0] memData,
  input  logic              advance,
  input  logic              hasImm,
  output logic              advReady,
  input  logic              jumpLoad,
  input  logic [WORD_W-1:0] jumpAddr,
  output logic [WORD_W-1:0] icOut,
  output logic [WORD_W-1:0] execWord,
  output logic              execValid,
  output logic [WORD_W-1:0] fetchWord,
  output logic              fetchValid,
  output logic [WORD_W-1:0] immWord
);
  pfqStrobes_t strobes;

  pfq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memRdy     (memRdy),
    .advance    (advance),
    .hasImm     (hasImm),
    .jumpLoad   (jumpLoad),
    .memReq     (memReq),
    .advReady   (advReady),
    .execValid  (execValid),
    .fetchValid (fetchValid),
    .strobes    (strobes)
  );

  pfq_datapath #(.WORD_W(WORD_W), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .jumpAddr  (jumpAddr),
    .memData   (memData),
    .icOut     (icOut),
    .execWord  (execWord),
    .fetchWord (fetchWord),
    .immWord   (immWord)
  );

  assign memAddr  = icOut;
  assign memInstr = memReq;
  assign memSpace = memReq;
  assign memRead  = memReq;
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memRdy,
  input logic              jumpLoad,
  input logic [WORD_W-1:0] jumpAddr,
  input logic [WORD_W-1:0] icOut,
  input logic              execValid,
  input logic              fetchValid,
  input logic [WORD_W-1:0] execWord,
  input logic [WORD_W-1:0] fetchWord,
  input logic [WORD_W-1:0] immWord
);
  AST_IC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memRdy && !jumpLoad |=> icOut == $past(icOut) + 1'b1); // R1

  AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    jumpLoad |=> icOut == $past(jumpAddr) && !execValid && !fetchValid); // R2

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memRdy && fetchValid && !execValid && !jumpLoad
    |=> execWord == $past(fetchWord) && immWord == fetchWord); // R5

  AST_IMM_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    execValid && !fetchValid && !jumpLoad |=> $stable(immWord)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdy && !jumpLoad
    |=> $stable(icOut) && $stable(execWord) && $stable(fetchWord)); // R9
endmodule

bind prefetch_queue prefetch_queue_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memRdy     (memRdy),
  .jumpLoad   (jumpLoad),
  .jumpAddr   (jumpAddr),
  .icOut      (icOut),
  .execValid  (execValid),
  .fetchValid (fetchValid),
  .execWord   (execWord),
  .fetchWord  (fetchWord),
  .immWord    (immWord)
);

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memInstr, memSpace, memRead, memRdy;
  logic [15:0] memAddr, memData, jumpAddr, icOut, execWord, fetchWord, immWord;
  logic        advance, hasImm, advReady, jumpLoad, execValid, fetchValid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [15:0] word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A5A;
  endfunction

  assign memData = word(memAddr);

  prefetch_queue i_prefetch_queue (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
    .memInstr(memInstr), .memSpace(memSpace), .memRead(memRead),
    .memRdy(memRdy), .memData(memData), .advance(advance), .hasImm(hasImm),
    .advReady(advReady), .jumpLoad(jumpLoad), .jumpAddr(jumpAddr),
    .icOut(icOut), .execWord(execWord), .execValid(execValid),
    .fetchWord(fetchWord), .fetchValid(fetchValid), .immWord(immWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 ic", icOut, 0);
    chk("R3 valids", {execValid, fetchValid}, 0);
    chk("R3 req", memReq, 1);
    chk("R3 addr", memAddr, 0);
    chk("R8 flags on fetch", {memInstr, memSpace, memRead}, 3'b111);
    chk("R1 addr equals ic", memAddr, icOut);
  endtask

  task automatic t_stall();
    memRdy = 1'b0;
    repeat (3) step();
    chk("R9 ic held", icOut, 0);
    chk("R9 fetch slot empty", fetchValid, 0);
  endtask

  task automatic t_fill();
    memRdy = 1'b1;
    step();
    chk("R4 fetch word", fetchWord, word(16'd0));
    chk("R4 valids", {execValid, fetchValid}, 2'b01);
    chk("R1 ic step", icOut, 1);
    step();
    memRdy = 1'b0;
    chk("R5 exec word", execWord, word(16'd0));
    chk("R5 fetch word", fetchWord, word(16'd1));
    chk("R5 imm word", immWord, word(16'd1));
    chk("R5 valids", {execValid, fetchValid}, 2'b11);
    chk("R1 ic two", icOut, 2);
    chk("R8 flags idle", {memReq, memInstr, memSpace, memRead}, 4'b0000);
    chk("R7 ready", advReady, 1);
  endtask

  task automatic t_advance();
    advance = 1'b1;
    step();
    chk("R7 exec cleared", {execValid, fetchValid}, 2'b01);
    chk("R7 request", memReq, 1);
    step();
    chk("R9 advance ignored", {execValid, fetchValid, icOut}, {2'b01, 16'd2});
    advance = 1'b0;
    memRdy = 1'b1;
    step();
    memRdy = 1'b0;
    chk("R7 shift exec", execWord, word(16'd1));
    chk("R7 shift fetch", fetchWord, word(16'd2));
    chk("R5 imm load", immWord, word(16'd2));
    chk("R1 ic three", icOut, 3);
  endtask

  task automatic t_imm();
    hasImm = 1'b1;
    step();
    chk("R6 fetch refetch", fetchValid, 0);
    chk("R6 exec kept", execWord, word(16'd1));
    chk("R6 imm kept", immWord, word(16'd2));
    chk("R7 not ready", advReady, 0);
    chk("R1 addr", memAddr, 3);
    memRdy = 1'b1;
    step();
    memRdy = 1'b0;
    chk("R6 new fetch", fetchWord, word(16'd3));
    chk("R6 imm after refetch", immWord, word(16'd2));
    chk("R6 no second refetch", {fetchValid, advReady, memReq}, 3'b110);
    advance = 1'b1;
    step();
    advance = 1'b0;
    hasImm = 1'b0;
    chk("R7 retire imm instr", execValid, 0);
    memRdy = 1'b1;
    step();
    memRdy = 1'b0;
    chk("R6 resume exec", execWord, word(16'd3));
    chk("R6 resume imm", immWord, word(16'd4));
    chk("R1 ic five", icOut, 5);
  endtask

  task automatic t_jump();
    advance = 1'b1;
    step();
    advance = 1'b0;
    jumpLoad = 1'b1;
    jumpAddr = 16'hFFFF;
    memRdy = 1'b1;
    #1;
    chk("R2 req blocked", memReq, 0);
    step();
    chk("R2 ic loaded", icOut, 16'hFFFF);
    chk("R2 flushed", {execValid, fetchValid}, 0);
    jumpLoad = 1'b0;
    #1;
    chk("R2 refill addr", memAddr, 16'hFFFF);
    step();
    chk("R2 first word", {execValid, fetchValid, fetchWord}, {2'b01, word(16'hFFFF)});
    chk("R1 wrap", icOut, 0);
    step();
    memRdy = 1'b0;
    chk("R2 exec word", execWord, word(16'hFFFF));
    chk("R2 fetch word", fetchWord, word(16'h0000));
    chk("R2 ic after refill", icOut, 1);
  endtask

  initial begin
    memRdy = 1'b0; advance = 1'b0; hasImm = 1'b0;
    jumpLoad = 1'b0; jumpAddr = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_fill();
    t_advance();
    t_imm();
    t_jump();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule